// File: doc/BRIEF.md
# Conditional Skip Sequencer

This block resolves the program-counter step of the two conditional skip operations in a small 8-bit instruction set. One is a register-equality test that skips when two registers hold the same value. The other is an I/O bit test that skips when a chosen bit of an I/O location is one. When the skip is taken, the following instruction is discarded. Because that instruction may be one or two program words long, the block also decodes the length of the next word so that it knows how far to step.

The fetch stage presents the current word, the word after it, and the current PC, and pulses `issue_valid`. The block drives the register-file and I/O read addresses combinationally from the current word, and it expects the read data back in the same cycle. One clock later it returns the new PC, the number of cycles the operation costs, and a flag that tells whether the next instruction was discarded. Status flags are never touched.

Top module: `skip_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `res_valid`, `res_pc`, `res_cycles` and `res_skip` to zero.
- R2: A current word with `cur_word[15:10] == 6'b000100` is a register-equality skip. It reads register {w[8],w[7:4]} on port A and register {w[9],w[3:0]} on port B, and its condition holds when all 8 bits of the two values are equal.
- R3: A current word with `cur_word[15:8] == 8'h9B` is an I/O bit skip. Its I/O address is `w[7:3]` and its bit index is `w[2:0]`, and its condition holds when that bit of `io_data` is 1.
- R4: When a skip operation's condition is false, the result is PC+1, 1 cycle, and `res_skip` = 0, whatever `next_word` holds.
- R5: When the condition holds and the next word is a one-word instruction, the result is PC+2, 2 cycles, and `res_skip` = 1.
- R6: When the condition holds and the next word is a two-word instruction, the result is PC+3, 3 cycles, and `res_skip` = 1. The two-word instructions are long jump or long call (`w[15:9]==7'b1001010`, `w[3:2]==2'b11`) and direct load or store (`w[15:10]==6'b100100`, `w[3:0]==4'b0000`).
- R7: A current word that is neither skip operation gives PC+1, 1 cycle, and `res_skip` = 0.
- R8: `res_valid` rises exactly one clock after a cycle with `issue_valid` high, and it is low after a cycle with `issue_valid` low. The result fields hold their values between issues.
- R9: The PC arithmetic wraps modulo 2^PC_W.
- R10: With `HAS_LONG_FLOW` = 0, the long jump and long call patterns count as one-word instructions. Direct load and store still count as two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Current word, next word and PC are valid this cycle |
| pc | input | PC_W | PC of the current word |
| cur_word | input | 16 | Instruction word being executed |
| next_word | input | 16 | Instruction word that follows |
| rf_addr_a | output | 5 | Register read address A |
| rf_addr_b | output | 5 | Register read address B |
| rf_data_a | input | 8 | Register read data A, same cycle |
| rf_data_b | input | 8 | Register read data B, same cycle |
| io_addr | output | 5 | I/O read address |
| io_data | input | 8 | I/O read data, same cycle |
| res_valid | output | 1 | Result valid pulse |
| res_pc | output | PC_W | PC after the operation |
| res_cycles | output | 2 | Cycle cost, 1 to 3 |
| res_skip | output | 1 | Next instruction was discarded |

## Verification
The bench builds two copies of the block. One uses the defaults (PC_W = 16, long flow and direct memory detection both on), so PC wrap from 0xFFFF and all three step sizes can be reached. The other uses PC_W = 8 with long-flow detection off. That copy reaches wrap at 0xFF, and it shows that long jump and long call then cost only two cycles while direct load and store still cost three.

// File: rtl/skip_pkg.sv
// Package: shared opcode masks and the operation kind for the skip sequencer.
// Assumes 16-bit instruction words.
package skip_pkg;

    typedef enum logic [1:0] {
        SKOP_NONE  = 2'd0,
        SKOP_REGEQ = 2'd1,
        SKOP_IOBIT = 2'd2
    } skip_op_e;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned RADDR_W  = 5;
    localparam int unsigned IOADDR_W = 5;
    localparam int unsigned DATA_W   = 8;

    localparam logic [15:0] REGEQ_MASK = 16'hFC00;
    localparam logic [15:0] REGEQ_PAT  = 16'h1000;
    localparam logic [15:0] IOBIT_MASK = 16'hFF00;
    localparam logic [15:0] IOBIT_PAT  = 16'h9B00;
    // long jump / long call
    localparam logic [15:0] LFLOW_MASK = 16'hFE0C;
    localparam logic [15:0] LFLOW_PAT  = 16'h940C;
    // direct load / direct store
    localparam logic [15:0] DMEM_MASK  = 16'hFC0F;
    localparam logic [15:0] DMEM_PAT   = 16'h9000;

endpackage

// File: rtl/skip_op_decode.sv
// Module: skip_op_decode
// Classifies the current word as a register-equality skip, an I/O bit skip
// or neither, and extracts the operand fields. Purely combinational.
module skip_op_decode
    import skip_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    output skip_op_e            op,
    output logic [RADDR_W-1:0]  reg_a,
    output logic [RADDR_W-1:0]  reg_b,
    output logic [IOADDR_W-1:0] io_sel,
    output logic [2:0]          bit_sel
);

    // Match the opcode patterns in a fixed priority (they are disjoint).
    always_comb begin
        if ((word & REGEQ_MASK) == REGEQ_PAT)
            op = SKOP_REGEQ;
        else if ((word & IOBIT_MASK) == IOBIT_PAT)
            op = SKOP_IOBIT;
        else
            op = SKOP_NONE;
    end

    // Operand fields; they are meaningful only for the matching operation.
    always_comb begin
        reg_a   = {word[8], word[7:4]};
        reg_b   = {word[9], word[3:0]};
        io_sel  = word[7:3];
        bit_sel = word[2:0];
    end

endmodule

// File: rtl/skip_len_decode.sv
// Module: skip_len_decode
// Reports whether an instruction word is the first word of a two-word
// instruction. Parameters select which two-word families the core has.
module skip_len_decode
    import skip_pkg::*;
#(
    parameter bit HAS_LONG_FLOW  = 1'b1,
    parameter bit HAS_DIRECT_MEM = 1'b1
) (
    input  logic [WORD_W-1:0] word,
    output logic              two_word
);

    logic lflow_hit;
    logic dmem_hit;

    generate
        if (HAS_LONG_FLOW) begin : g_lflow
            // Long jump or long call opcode.
            assign lflow_hit = ((word & LFLOW_MASK) == LFLOW_PAT);
        end else begin : g_no_lflow
            assign lflow_hit = 1'b0;
        end

        if (HAS_DIRECT_MEM) begin : g_dmem
            // Direct load or direct store opcode.
            assign dmem_hit = ((word & DMEM_MASK) == DMEM_PAT);
        end else begin : g_no_dmem
            assign dmem_hit = 1'b0;
        end
    endgenerate

    // Combine the families.
    always_comb two_word = lflow_hit | dmem_hit;

endmodule

// File: rtl/skip_cond.sv
// Module: skip_cond
// Evaluates the skip condition from the read data. Register equality
// compares all bits and affects no flags. Combinational.
module skip_cond
    import skip_pkg::*;
(
    input  skip_op_e            op,
    input  logic [DATA_W-1:0]   a_val,
    input  logic [DATA_W-1:0]   b_val,
    input  logic [DATA_W-1:0]   io_val,
    input  logic [2:0]          bit_sel,
    output logic                take
);

    // Select the condition of the decoded operation.
    always_comb begin
        unique case (op)
            SKOP_REGEQ: take = (a_val == b_val);
            SKOP_IOBIT: take = io_val[bit_sel];
            default:    take = 1'b0;
        endcase
    end

endmodule

// File: rtl/skip_seq.sv
// Module: skip_seq (top)
// Resolves the PC step and the cycle cost of conditional skip operations.
// Assumes the register and I/O read data return in the same cycle as the
// address. The result is registered one clock after issue_valid.
module skip_seq
    import skip_pkg::*;
#(
    parameter int unsigned PC_W           = 16,
    parameter bit          HAS_LONG_FLOW  = 1'b1,
    parameter bit          HAS_DIRECT_MEM = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [PC_W-1:0]     pc,
    input  logic [15:0]         cur_word,
    input  logic [15:0]         next_word,
    output logic [4:0]          rf_addr_a,
    output logic [4:0]          rf_addr_b,
    input  logic [7:0]          rf_data_a,
    input  logic [7:0]          rf_data_b,
    output logic [4:0]          io_addr,
    input  logic [7:0]          io_data,
    output logic                res_valid,
    output logic [PC_W-1:0]     res_pc,
    output logic [1:0]          res_cycles,
    output logic                res_skip
);

    localparam logic [1:0] CYC_PLAIN = 2'd1;
    localparam logic [1:0] CYC_SKIP1 = 2'd2;
    localparam logic [1:0] CYC_SKIP2 = 2'd3;

    skip_op_e   op;
    logic [2:0] bit_sel;
    logic       take;
    logic       two_word;
    logic [1:0] cyc_nx;
    logic [PC_W-1:0] pc_nx;

    skip_op_decode u_op_dec (
        .word    (cur_word),
        .op      (op),
        .reg_a   (rf_addr_a),
        .reg_b   (rf_addr_b),
        .io_sel  (io_addr),
        .bit_sel (bit_sel)
    );

    skip_len_decode #(
        .HAS_LONG_FLOW  (HAS_LONG_FLOW),
        .HAS_DIRECT_MEM (HAS_DIRECT_MEM)
    ) u_len_dec (
        .word     (next_word),
        .two_word (two_word)
    );

    skip_cond u_cond (
        .op      (op),
        .a_val   (rf_data_a),
        .b_val   (rf_data_b),
        .io_val  (io_data),
        .bit_sel (bit_sel),
        .take    (take)
    );

    // Step size: one word, or one plus the length of the discarded word.
    always_comb begin
        if (!take)
            cyc_nx = CYC_PLAIN;
        else if (two_word)
            cyc_nx = CYC_SKIP2;
        else
            cyc_nx = CYC_SKIP1;
        pc_nx = pc + PC_W'(cyc_nx);
    end

    // Result register: pulse valid and capture the step for each issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_pc     <= '0;
            res_cycles <= 2'd0;
            res_skip   <= 1'b0;
        end else begin
            res_valid <= issue_valid;
            if (issue_valid) begin
                res_pc     <= pc_nx;
                res_cycles <= cyc_nx;
                res_skip   <= take;
            end
        end
    end

    AST_VALID_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(issue_valid)); // R8
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pc == $past(pc) + PC_W'(res_cycles))); // R9
    AST_NOSKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_skip) |-> (res_cycles == 2'd1)); // R4
    AST_SKIP_MULTI_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_skip) |-> (res_cycles == 2'd2 || res_cycles == 2'd3)); // R5
    AST_NONSKIP_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ((cur_word & REGEQ_MASK) != REGEQ_PAT)
                     && ((cur_word & IOBIT_MASK) != IOBIT_PAT)) |=> !res_skip); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> ($stable(res_pc) && $stable(res_cycles))); // R8

endmodule

// File: tb/skip_seq_tb.sv
module skip_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [15:0] pc = '0;
    logic [15:0] cur_word = '0;
    logic [15:0] next_word = '0;

    logic [7:0] rf [32];
    logic [7:0] iom [32];

    logic [4:0]  a_addr, b_addr, i_addr, sa_addr, sb_addr, si_addr;
    logic        rv, rs, srv, srs;
    logic [15:0] rpc;
    logic [7:0]  srpc;
    logic [1:0]  rc, src;

    int checks = 0;
    int errors = 0;
    int cycles_run = 0;

    always #5 clk = ~clk;

    skip_seq u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .pc(pc),
        .cur_word(cur_word), .next_word(next_word),
        .rf_addr_a(a_addr), .rf_addr_b(b_addr),
        .rf_data_a(rf[a_addr]), .rf_data_b(rf[b_addr]),
        .io_addr(i_addr), .io_data(iom[i_addr]),
        .res_valid(rv), .res_pc(rpc), .res_cycles(rc), .res_skip(rs)
    );

    skip_seq #(.PC_W(8), .HAS_LONG_FLOW(1'b0), .HAS_DIRECT_MEM(1'b1)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .pc(pc[7:0]),
        .cur_word(cur_word), .next_word(next_word),
        .rf_addr_a(sa_addr), .rf_addr_b(sb_addr),
        .rf_data_a(rf[sa_addr]), .rf_data_b(rf[sb_addr]),
        .io_addr(si_addr), .io_data(iom[si_addr]),
        .res_valid(srv), .res_pc(srpc), .res_cycles(src), .res_skip(srs)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit cond_of(input logic [15:0] w);
        if (w[15:10] == 6'b000100)
            return rf[{w[8], w[7:4]}] == rf[{w[9], w[3:0]}];
        if (w[15:8] == 8'h9B)
            return iom[w[7:3]][w[2:0]];
        return 1'b0;
    endfunction

    function automatic bit long_of(input logic [15:0] w, input bit lflow);
        bit jc = (w[15:9] == 7'b1001010) && (w[3:2] == 2'b11);
        bit dm = (w[15:10] == 6'b100100) && (w[3:0] == 4'b0000);
        return (jc && lflow) || dm;
    endfunction

    function automatic int steps_of(input logic [15:0] c, input logic [15:0] n, input bit lflow);
        if (!cond_of(c)) return 1;
        return long_of(n, lflow) ? 3 : 2;
    endfunction

    // Issue one operation and check both copies one clock later.
    task automatic run(input logic [15:0] c, input logic [15:0] n,
                       input logic [15:0] p, input string req);
        int es, ess;
        @(negedge clk);
        cur_word = c; next_word = n; pc = p; issue_valid = 1'b1;
        es  = steps_of(c, n, 1'b1);
        ess = steps_of(c, n, 1'b0);
        @(negedge clk);
        issue_valid = 1'b0;
        chk(rv == 1'b1, req, rv, 1);
        chk(rpc == 16'(p + 16'(es)), req, rpc, 16'(p + 16'(es)));
        chk(rc == 2'(es), req, rc, es);
        chk(rs == (es > 1), req, rs, es > 1);
        chk(srpc == 8'(p[7:0] + 8'(ess)), req, srpc, 8'(p[7:0] + 8'(ess)));
        chk(src == 2'(ess), req, src, ess);
    endtask

    always @(posedge clk) begin
        cycles_run <= cycles_run + 1;
        if (cycles_run > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles_run, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        foreach (rf[i]) rf[i] = 8'(i);
        foreach (iom[i]) iom[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rv == 0 && rpc == 0 && rc == 0 && rs == 0, "R1", {rv, rs, rc}, 0);
        rst_n = 1'b1;

        // R2: register-equality, unequal values, decoded addresses
        rf[2] = 8'd10; rf[3] = 8'd11;
        @(negedge clk); cur_word = 16'h1023;
        #1 chk(a_addr == 5'd2 && b_addr == 5'd3, "R2", {a_addr, b_addr}, {5'd2, 5'd3});
        cur_word = 16'h1230; // d = {0,0011}=3? check high bits: d=bit8, r=bit9
        #1 chk(a_addr == 5'd3 && b_addr == 5'd16, "R2", {a_addr, b_addr}, {5'd3, 5'd16});
        run(16'h1023, 16'h940E, 16'h0040, "R4");
        rf[3] = 8'd10;
        run(16'h1023, 16'h921C, 16'h0040, "R5");
        run(16'h1023, 16'h940E, 16'h0040, "R6");
        run(16'h1023, 16'h940C, 16'h0010, "R10");
        run(16'h1023, 16'h9100, 16'h0010, "R6");
        run(16'h1023, 16'h9330, 16'h0010, "R6");
        rf[2] = 8'h8A; rf[3] = 8'h0A; // differ only in the top bit
        run(16'h1023, 16'h921C, 16'h0020, "R2");

        // R3: I/O bit test at I/O 0x0C, bit 5
        @(negedge clk); cur_word = 16'h9B65;
        #1 chk(i_addr == 5'h0C, "R3", i_addr, 5'h0C);
        iom[12] = 8'b0000_1111;
        run(16'h9B65, 16'h921C, 16'h0100, "R3");
        iom[12] = 8'b0010_1111;
        run(16'h9B65, 16'h921C, 16'h0100, "R3");
        run(16'h9B65, 16'h940E, 16'h0100, "R6");

        // R7: words that are not skip operations
        run(16'h0000, 16'h940E, 16'h0005, "R7");
        run(16'h9B00 ^ 16'h0100, 16'h940E, 16'h0005, "R7");

        // R9: wrap at the top of the PC range
        run(16'h9B65, 16'h940E, 16'hFFFF, "R9");
        run(16'h9B65, 16'h921C, 16'h00FE, "R9");

        // R8: no valid after an idle cycle
        @(negedge clk);
        chk(rv == 1'b0 && srv == 1'b0, "R8", rv, 0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [15:0] c, n;
            int sel;
            foreach (rf[i]) rf[i] = 8'($urandom_range(0, 3));
            foreach (iom[i]) iom[i] = 8'($urandom);
            sel = $urandom_range(0, 2);
            c = 16'($urandom);
            if (sel == 0) c = {6'b000100, c[9:0]};
            else if (sel == 1) c = {8'h9B, c[7:0]};
            n = 16'($urandom);
            sel = $urandom_range(0, 3);
            if (sel == 0) n = {7'b1001010, n[8:4], 2'b11, n[1:0]};
            else if (sel == 1) n = {6'b100100, n[9:4], 4'b0000};
            run(c, n, 16'($urandom), "R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule